// File: doc/BRIEF.md
# Multi-Byte SPI Transaction Sequencer

This block lets user logic run a serial transaction of several words through a single-word SPI master engine, without handling the engine's per-word handshake itself. The caller places up to `MAX_WORDS` words on a flat transmit array, gives a word count and pulses `start`. The sequencer passes the words to the engine one at a time, in index order. For each word it raises a one-cycle send request. It then waits until the engine shows busy and afterwards waits until busy clears. At that point it stores the engine's received word in the matching slot of a flat receive array.

After the final word, the sequencer raises `done` for one cycle. `active` marks the whole transaction. Serial pin timing belongs to the engine and is not part of this block. The transmit array is read live, so the caller keeps it stable while `active` is high.

Top module: `spi_burst_seq`

## Requirements
- R1: While reset is applied, and in the cycle after a synchronous reset, `active`, `done` and `eng_send` are low and every bit of `rx_array` is zero.
- R2: For a start with count N (1..MAX_WORDS) accepted in idle, exactly N words are offered to the engine, word i being `tx_array[i*WORD_W +: WORD_W]`, in ascending order of i.
- R3: `eng_send` is never high for two consecutive cycles.
- R4: After a send request, no further request is made until `eng_busy` has been seen high and then low; a busy that rises several cycles late is still waited for.
- R5: When busy falls for word i, `eng_rxd` is stored in `rx_array[i*WORD_W +: WORD_W]`; slots at or above N keep their earlier contents.
- R6: `done` is high for exactly one cycle, one cycle after busy is sampled low for the last word.
- R7: `active` is high from the cycle after a start is accepted through the `done` cycle, and low in idle.
- R8: A count of 0 makes no send request and raises `done` in the cycle after start.
- R9: A count above MAX_WORDS is treated as MAX_WORDS.
- R10: A start while `active` is high is ignored: the transaction in flight keeps its count and no extra words are sent.
- R11: A synchronous reset in the middle of a transaction returns the block to idle with no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (ignored unless idle) |
| count | input | CNT_W | Number of words, 0..2^CNT_W-1, clamped to MAX_WORDS |
| tx_array | input | MAX_WORDS*WORD_W | Words to send, word i at bits i*WORD_W upward |
| rx_array | output | MAX_WORDS*WORD_W | Received words, same layout |
| active | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| eng_send | output | 1 | One-cycle send request to the engine |
| eng_txd | output | WORD_W | Word offered to the engine |
| eng_busy | input | 1 | Engine busy flag |
| eng_rxd | input | WORD_W | Word received by the engine |

## Verification
Every cycle, the embedded assertions check the following: the single-cycle request and done pulses, that done only appears while active, that no request is made while the engine is busy, and that the word index only steps by one or returns to zero, staying below the loaded length. Only the directed scenarios can show the rest. These cover the word ordering against the transmit array and the placement of received words. They also cover waiting through a late-rising busy, clamping of oversize counts, the zero-count shortcut, ignoring a second start, and recovery from a reset in the middle of a transaction.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_ISSUE   = 3'd1,
      SQ_WAIT_HI = 3'd2,
      SQ_WAIT_LO = 3'd3,
      SQ_DONE    = 3'd4
   } sq_state_e;
endpackage

// File: rtl/spi_burst_idx.sv
module spi_burst_idx #(
   parameter int MAX_WORDS = 16,
   parameter int CNT_W     = 5,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] len_in,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             len_zero,
   output logic             last
);
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] idx_ext;

   assign idx_ext  = CNT_W'(idx);
   assign last     = (idx_ext + CNT_W'(1)) == len_q;
   assign len_zero = (len_in == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx   <= '0;
         len_q <= '0;
      end else if (load) begin
         idx   <= '0;
         len_q <= len_in;
      end else if (advance) begin
         idx   <= idx + IDX_W'(1);
      end
   end

   // R5 / R2: index walks upward one slot at a time, or restarts at zero
   a_r5_idx_step : assert property (@(posedge clk) disable iff (rst)
      !$stable(idx) |-> (idx == '0 || idx == $past(idx) + IDX_W'(1)));
   a_r2_idx_in_range : assert property (@(posedge clk) disable iff (rst)
      (len_q != '0) |-> (idx_ext < len_q));
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
   import spi_burst_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic len_zero,
   input  logic last,
   input  logic eng_busy,
   output logic load,
   output logic advance,
   output logic capture,
   output logic send,
   output logic active,
   output logic done
);
   sq_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      load     = 1'b0;
      advance  = 1'b0;
      capture  = 1'b0;
      unique case (state)
         SQ_IDLE: if (start) begin
            load     = 1'b1;
            state_nx = len_zero ? SQ_DONE : SQ_ISSUE;
         end
         SQ_ISSUE:   state_nx = SQ_WAIT_HI;
         SQ_WAIT_HI: if (eng_busy) state_nx = SQ_WAIT_LO;
         SQ_WAIT_LO: if (!eng_busy) begin
            capture = 1'b1;
            if (last) state_nx = SQ_DONE;
            else begin
               advance  = 1'b1;
               state_nx = SQ_ISSUE;
            end
         end
         SQ_DONE:    state_nx = SQ_IDLE;
         default:    state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SQ_IDLE;
      else     state <= state_nx;
   end

   assign send   = (state == SQ_ISSUE);
   assign active = (state != SQ_IDLE);
   assign done   = (state == SQ_DONE);

   a_r3_send_one_cycle : assert property (@(posedge clk) disable iff (rst)
      send |=> !send);
   a_r6_done_one_cycle : assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r7_done_in_active : assert property (@(posedge clk) disable iff (rst)
      done |-> active);
   a_r4_no_send_when_busy : assert property (@(posedge clk) disable iff (rst)
      send |-> !eng_busy);
   a_r10_start_ignored : assert property (@(posedge clk) disable iff (rst)
      (active && !done && start) |=> active);
endmodule

// File: rtl/spi_burst_rxbank.sv
module spi_burst_rxbank #(
   parameter int MAX_WORDS = 16,
   parameter int WORD_W    = 8,
   parameter int IDX_W     = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        capture,
   input  logic [IDX_W-1:0]            idx,
   input  logic [WORD_W-1:0]           rxd,
   output logic [MAX_WORDS*WORD_W-1:0] rx_flat
);
   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (rst)                                  slot_q <= '0;
         else if (capture && idx == IDX_W'(g))     slot_q <= rxd;
      end
      assign rx_flat[g*WORD_W +: WORD_W] = slot_q;
   end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq #(
   parameter int WORD_W    = 8,
   parameter int MAX_WORDS = 16,
   parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        start,
   input  logic [CNT_W-1:0]            count,
   input  logic [MAX_WORDS*WORD_W-1:0] tx_array,
   output logic [MAX_WORDS*WORD_W-1:0] rx_array,
   output logic                        active,
   output logic                        done,
   output logic                        eng_send,
   output logic [WORD_W-1:0]           eng_txd,
   input  logic                        eng_busy,
   input  logic [WORD_W-1:0]           eng_rxd
);
   localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

   if (WORD_W < 1) begin : g_bad_word
      $error("spi_burst_seq: WORD_W must be at least 1");
   end
   if (MAX_WORDS < 1) begin : g_bad_depth
      $error("spi_burst_seq: MAX_WORDS must be at least 1");
   end
   if ((2 ** CNT_W) <= MAX_WORDS) begin : g_bad_cnt
      $error("spi_burst_seq: CNT_W too narrow for MAX_WORDS");
   end

   logic [CNT_W-1:0] len_clamped;
   logic [IDX_W-1:0] idx;
   logic load, advance, capture, len_zero, last;

   assign len_clamped = (count > CNT_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS) : count;

   spi_burst_idx #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst(rst), .load(load), .len_in(len_clamped),
      .advance(advance), .idx(idx), .len_zero(len_zero), .last(last));

   spi_burst_ctrl u_ctrl (
      .clk(clk), .rst(rst), .start(start), .len_zero(len_zero), .last(last),
      .eng_busy(eng_busy), .load(load), .advance(advance), .capture(capture),
      .send(eng_send), .active(active), .done(done));

   spi_burst_rxbank #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_rx (
      .clk(clk), .rst(rst), .capture(capture), .idx(idx), .rxd(eng_rxd),
      .rx_flat(rx_array));

   assign eng_txd = tx_array[idx*WORD_W +: WORD_W];

   // R1 / R11: nothing is requested or reported in the cycle after reset
   a_r11_quiet_after_reset : assert property (@(posedge clk)
      $past(rst) |-> (!active && !done && !eng_send));
   a_r8_done_needs_active : assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(active) || $past(start));
endmodule

// File: tb/sim_spi_burst_seq.sv
`timescale 1ns/1ps
module sim_spi_burst_seq;
   localparam int W = 8;
   localparam int M = 16;
   localparam int CW = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [CW-1:0] count = '0;
   logic [M*W-1:0] tx_array = '0;
   logic [M*W-1:0] rx_array;
   logic active, done, eng_send, eng_busy;
   logic [W-1:0] eng_txd, eng_rxd;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   spi_burst_seq #(.WORD_W(W), .MAX_WORDS(M)) u0 (
      .clk(clk), .rst(rst), .start(start), .count(count), .tx_array(tx_array),
      .rx_array(rx_array), .active(active), .done(done), .eng_send(eng_send),
      .eng_txd(eng_txd), .eng_busy(eng_busy), .eng_rxd(eng_rxd));

   // behavioural engine stub: answers word x with x ^ 8'h5A
   int rise_dly = 0, busy_len = 2;
   int st = 0, cnt = 0, n_sent = 0;
   int viol_width = 0, viol_busy = 0;
   logic [W-1:0] hold_tx;
   logic [W-1:0] sent_log [64];
   logic prev_send = 1'b0;

   always @(posedge clk) begin
      prev_send <= eng_send;
      if (eng_send && prev_send) viol_width <= viol_width + 1;
      if (eng_send && (st != 0 || eng_busy)) viol_busy <= viol_busy + 1;
      if (rst) begin
         st <= 0; eng_busy <= 1'b0; eng_rxd <= '0;
      end else begin
         case (st)
            0: if (eng_send) begin
               sent_log[n_sent % 64] <= eng_txd;
               n_sent  <= n_sent + 1;
               hold_tx <= eng_txd;
               cnt     <= rise_dly;
               st      <= 1;
            end
            1: if (cnt == 0) begin
               eng_busy <= 1'b1; cnt <= busy_len; st <= 2;
            end else cnt <= cnt - 1;
            default: if (cnt == 0) begin
               eng_busy <= 1'b0; eng_rxd <= hold_tx ^ 8'h5A; st <= 0;
            end else cnt <= cnt - 1;
         endcase
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int n);
      @(negedge clk);
      count = CW'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req, output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 5000 && !seen; k++) begin
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
      chk(seen, req, 32'(seen), 1);
   endtask

   int seed = 1;
   task automatic fill_tx();
      for (int i = 0; i < M; i++) tx_array[i*W +: W] = W'(seed * 37 + i * 13 + 1);
      seed++;
   endtask

   task automatic run(input int n_req, input int dly, input int blen, input string req);
      int exp_n, base;
      bit seen, ok;
      logic [M*W-1:0] rx_prev;
      exp_n = (n_req > M) ? M : n_req;
      rise_dly = dly; busy_len = blen;
      fill_tx();
      rx_prev = rx_array;
      base = n_sent;
      pulse_start(n_req);
      chk(active == 1'b1, {req, " R7 active after start"}, 32'(active), 1);
      wait_done(req, seen);
      @(negedge clk);
      chk(done == 1'b0, {req, " R6 done one cycle"}, 32'(done), 0);
      chk(active == 1'b0, {req, " R7 idle after done"}, 32'(active), 0);
      repeat (3) @(negedge clk);
      chk(n_sent - base == exp_n, {req, " R2 word count"}, 32'(n_sent - base), 32'(exp_n));
      ok = 1'b1;
      for (int i = 0; i < exp_n; i++) begin
         if (sent_log[(base + i) % 64] != tx_array[i*W +: W]) ok = 1'b0;
         if (rx_array[i*W +: W] != (tx_array[i*W +: W] ^ 8'h5A)) ok = 1'b0;
      end
      chk(ok, {req, " R2 R5 word order and capture"}, 32'(ok), 1);
      ok = 1'b1;
      for (int i = exp_n; i < M; i++)
         if (rx_array[i*W +: W] != rx_prev[i*W +: W]) ok = 1'b0;
      chk(ok, {req, " R5 upper slots kept"}, 32'(ok), 1);
      chk(viol_width == 0, {req, " R3 send width"}, 32'(viol_width), 0);
      chk(viol_busy == 0, {req, " R4 send while busy"}, 32'(viol_busy), 0);
   endtask

   task automatic t_reset();
      chk(active == 1'b0 && done == 1'b0 && eng_send == 1'b0, "R1 idle outputs", {active, done, eng_send}, 0);
      chk(rx_array == '0, "R1 rx zero", 32'(rx_array[31:0]), 0);
   endtask

   task automatic t_zero();
      int base;
      base = n_sent;
      pulse_start(0);
      chk(done == 1'b1, "R8 done after zero count", 32'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single", 32'(done), 0);
      repeat (4) @(negedge clk);
      chk(n_sent == base, "R8 nothing sent", 32'(n_sent - base), 0);
   endtask

   task automatic t_ignore_start();
      int base;
      bit seen;
      rise_dly = 1; busy_len = 3;
      fill_tx();
      base = n_sent;
      pulse_start(5);
      repeat (4) @(negedge clk);
      pulse_start(2);
      wait_done("R10", seen);
      repeat (6) @(negedge clk);
      chk(n_sent - base == 5, "R10 second start ignored", 32'(n_sent - base), 5);
      chk(active == 1'b0, "R10 no new transaction", 32'(active), 0);
   endtask

   task automatic t_reset_mid();
      int base;
      rise_dly = 0; busy_len = 6;
      fill_tx();
      base = n_sent;
      pulse_start(4);
      repeat (12) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(active == 1'b0 && done == 1'b0 && eng_send == 1'b0, "R11 idle in reset", {active, done, eng_send}, 0);
      chk(rx_array == '0, "R1 rx cleared by reset", 32'(rx_array[31:0]), 0);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      chk(active == 1'b0 && eng_send == 1'b0, "R11 stays idle", {active, eng_send}, 0);
      chk(n_sent - base < 4, "R11 transaction abandoned", 32'(n_sent - base), 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      run(3, 0, 2, "R2 basic");
      run(2, 5, 1, "R4 late busy");
      run(16, 0, 0, "R2 full");
      run(2, 1, 2, "R5 partial");
      run(31, 0, 1, "R9 oversize");
      run(1, 0, 0, "R6 single");
      t_zero();
      t_ignore_start();
      t_reset_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule